// File: doc/BRIEF.md
# Fixed-Point Summing Stage with Rounding Preload and Slice Chaining

This block is the last adder of a fixed-point multiply-accumulate slice. It takes a signed product from an upstream multiplier and widens it to 64 bits. Four control bits, read on every valid cycle, then choose what the product is added to. The product may be added to nothing, which clears the running value. It may be added to a one-hot rounding constant. It may be added to the slice's own previous sum, either as it is or negated. Or it may be subtracted from the chain value coming from the neighbouring slice. The 64-bit sum is registered. The same register drives the result port and the chain output that feeds the next slice.

A slice that is set up as two independent small multipliers has no use for feedback or chaining. A mode input bypasses both in that case, so that the registered value is just the widened product. A small state machine records whether the feedback register holds a live sum (ST_RUNNING) or has been zeroed (ST_CLEARED). A synchronous clear or reset takes it to ST_CLEARED. A valid cycle without clear moves it to ST_RUNNING. The operation for each cycle is decoded into one of five named operations: OP_ZERO, OP_PRELOAD, OP_ACC, OP_ACC_NEG and OP_CHAIN_NEG.

Top module: `mac_sum_stage`

## Requirements
- R1: After reset (rst_n low), sum_q is 0 and sum_vld is 0.
- R2: With neg=0, ldc=0, acc=0, the registered sum equals the product sign-extended to 64 bits.
- R3: With acc=0 and ldc=1, the registered sum is the sign-extended product plus rnd_const. neg is ignored in this case, and rnd_const must have exactly one bit set.
- R4: With acc=1 and neg=0, the registered sum is the previous sum plus the sign-extended product, whatever ldc is.
- R5: With acc=1 and neg=1, the registered sum is the previous sum minus the sign-extended product.
- R6: With neg=1, ldc=0, acc=0, the registered sum is chain_in minus the sign-extended product.
- R7: When chain_off=1, the chain operand is zero, so the OP_CHAIN_NEG case yields minus the product.
- R8: When split_mode=1, the registered sum is the sign-extended product, whatever neg, ldc, acc and chain_in are.
- R9: sum_q, chain_out and sum_vld take the new value on the clock edge after a cycle with in_vld=1. chain_out always equals sum_q. A cycle with in_vld=0 leaves sum_q unchanged and drives sum_vld to 0.
- R10: A cycle with clr=1 sets sum_q to 0 and sum_vld to 0 on the next edge, even if in_vld=1 in that cycle. The next accumulation then starts from 0.
- R11: The 64-bit sum wraps modulo 2^64 and never saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the feedback register |
| in_vld | input | 1 | Inputs of this cycle are valid |
| split_mode | input | 1 | Two-independent-multiplier configuration; bypasses feedback and chain |
| neg | input | 1 | Negate the current product |
| ldc | input | 1 | Add the rounding constant |
| acc | input | 1 | Add the previous sum |
| chain_off | input | 1 | Force the chain operand to zero |
| prod | input | PROD_W | Signed product from the multiplier stage |
| chain_in | input | ACC_W | Chain value from the previous slice |
| rnd_const | input | ACC_W | One-hot rounding constant |
| sum_q | output | ACC_W | Registered sum |
| chain_out | output | ACC_W | Chain value to the next slice |
| sum_vld | output | 1 | sum_q was updated on the last edge |

## Verification
The case that is hardest to reach from the ports is the carry across bit 63. Products are at most 38 bits wide, so an accumulation alone would take a very long time to reach it. The stimulus gets there quickly with a preload of bit 63 on a product of -1, which gives the largest positive value, and then accumulates +1 so the sum wraps to the most negative value. A randomized run of back-to-back operations then mixes control combinations that overlap, such as ldc set together with acc or neg. It also checks them against a priority model inside the bench.

// File: rtl/mac_sum_pkg.sv
package mac_sum_pkg;
    typedef enum logic [2:0] {
        OP_ZERO,
        OP_PRELOAD,
        OP_ACC,
        OP_ACC_NEG,
        OP_CHAIN_NEG
    } sum_op_e;

    typedef enum logic {
        ST_CLEARED,
        ST_RUNNING
    } fb_state_e;
endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
    import mac_sum_pkg::*;
(
    input  logic    split_mode,
    input  logic    neg,
    input  logic    ldc,
    input  logic    acc,
    output sum_op_e op
);
    // Fixed priority: split bypass, then accumulate, then preload, then chain.
    always_comb begin
        if (split_mode)       op = OP_ZERO;
        else if (acc && neg)  op = OP_ACC_NEG;
        else if (acc)         op = OP_ACC;
        else if (ldc)         op = OP_PRELOAD;
        else if (neg)         op = OP_CHAIN_NEG;
        else                  op = OP_ZERO;
    end
endmodule

// File: rtl/mac_operand_sel.sv
module mac_operand_sel
    import mac_sum_pkg::*;
#(
    parameter int PROD_W = 38,
    parameter int ACC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  sum_op_e           op,
    input  logic [PROD_W-1:0] prod,
    input  logic [ACC_W-1:0]  feedback,
    input  logic [ACC_W-1:0]  chain_in,
    input  logic              chain_off,
    input  logic [ACC_W-1:0]  rnd_const,
    output logic [ACC_W-1:0]  prod_ext,
    output logic [ACC_W-1:0]  term_a,
    output logic [ACC_W-1:0]  term_b
);
    localparam int EXT_W = ACC_W - PROD_W;

    generate
        if (EXT_W > 0) begin : g_sext
            assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        end else begin : g_same
            assign prod_ext = prod;
        end
    endgenerate

    logic [ACC_W-1:0] prod_neg;
    logic [ACC_W-1:0] chain_term;

    assign prod_neg   = ~prod_ext + {{(ACC_W-1){1'b0}}, 1'b1};
    assign chain_term = chain_off ? '0 : chain_in;

    always_comb begin
        unique case (op)
            OP_ZERO: begin
                term_a = prod_ext;
                term_b = '0;
            end
            OP_PRELOAD: begin
                term_a = prod_ext;
                term_b = rnd_const;
            end
            OP_ACC: begin
                term_a = prod_ext;
                term_b = feedback;
            end
            OP_ACC_NEG: begin
                term_a = prod_neg;
                term_b = feedback;
            end
            OP_CHAIN_NEG: begin
                term_a = prod_neg;
                term_b = chain_term;
            end
            default: begin
                term_a = prod_ext;
                term_b = '0;
            end
        endcase
    end

    // The rounding constant must carry exactly one set bit when it is used.
    assert_preload_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == OP_PRELOAD) |-> ($countones(rnd_const) == 1));
endmodule

// File: rtl/mac_sum_stage.sv
module mac_sum_stage
    import mac_sum_pkg::*;
#(
    parameter int PROD_W = 38,
    parameter int ACC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_vld,
    input  logic              split_mode,
    input  logic              neg,
    input  logic              ldc,
    input  logic              acc,
    input  logic              chain_off,
    input  logic [PROD_W-1:0] prod,
    input  logic [ACC_W-1:0]  chain_in,
    input  logic [ACC_W-1:0]  rnd_const,
    output logic [ACC_W-1:0]  sum_q,
    output logic [ACC_W-1:0]  chain_out,
    output logic              sum_vld
);
    sum_op_e          op;
    fb_state_e        state_q, state_d;
    logic [ACC_W-1:0] feedback, prod_ext, term_a, term_b, sum_d;

    mac_op_decode i_decode (
        .split_mode (split_mode),
        .neg        (neg),
        .ldc        (ldc),
        .acc        (acc),
        .op         (op)
    );

    // In ST_CLEARED the feedback operand is zero.
    assign feedback = (state_q == ST_RUNNING) ? sum_q : '0;

    mac_operand_sel #(.PROD_W(PROD_W), .ACC_W(ACC_W)) i_operands (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .op        (op),
        .prod      (prod),
        .feedback  (feedback),
        .chain_in  (chain_in),
        .chain_off (chain_off),
        .rnd_const (rnd_const),
        .prod_ext  (prod_ext),
        .term_a    (term_a),
        .term_b    (term_b)
    );

    assign sum_d = term_a + term_b;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEARED: if (!clr && in_vld) state_d = ST_RUNNING;
            ST_RUNNING: if (clr)            state_d = ST_CLEARED;
            default:                        state_d = ST_CLEARED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEARED;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            sum_vld <= 1'b0;
        end else if (clr) begin
            sum_q   <= '0;
            sum_vld <= 1'b0;
        end else begin
            sum_vld <= in_vld;
            if (in_vld) sum_q <= sum_d;
        end
    end

    assign chain_out = sum_q;

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !clr) |=> sum_vld);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !clr) |=> ($stable(sum_q) && !sum_vld));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0 && !sum_vld));

    assert_split_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !clr && split_mode) |=> (sum_q == $past(prod_ext)));
endmodule

// File: tb/test_mac_sum_stage.sv
module test_mac_sum_stage;
    localparam int PW = 38;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0, in_vld = 1'b0, split_mode = 1'b0;
    logic          neg = 1'b0, ldc = 1'b0, acc = 1'b0, chain_off = 1'b0;
    logic [PW-1:0] prod = '0;
    logic [AW-1:0] chain_in = '0, rnd_const = 64'd1;
    logic [AW-1:0] sum_q, chain_out;
    logic          sum_vld;

    always #5 clk = ~clk;

    mac_sum_stage #(.PROD_W(PW), .ACC_W(AW)) i_mac_sum_stage (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
        .split_mode(split_mode), .neg(neg), .ldc(ldc), .acc(acc),
        .chain_off(chain_off), .prod(prod), .chain_in(chain_in),
        .rnd_const(rnd_const), .sum_q(sum_q), .chain_out(chain_out),
        .sum_vld(sum_vld)
    );

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    item_t         sb[$];
    int            n_chk = 0, n_fail = 0;
    logic [AW-1:0] model = '0;
    bit            done = 1'b0;

    function automatic logic [AW-1:0] sext(input logic [PW-1:0] p);
        return {{(AW-PW){p[PW-1]}}, p};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one valid operation and pushes the expected sum.
    task automatic drive(input string tag, input logic s, input logic n, input logic l,
                         input logic a, input logic co, input logic [PW-1:0] p,
                         input logic [AW-1:0] ch, input logic [AW-1:0] rc);
        logic [AW-1:0] e;
        @(negedge clk);
        split_mode = s; neg = n; ldc = l; acc = a; chain_off = co;
        prod = p; chain_in = ch; rnd_const = rc; in_vld = 1'b1; clr = 1'b0;
        if (s)            e = sext(p);                      // R8
        else if (a && n)  e = model - sext(p);              // R5
        else if (a)       e = model + sext(p);              // R4
        else if (l)       e = sext(p) + rc;                 // R3
        else if (n)       e = (co ? '0 : ch) - sext(p);     // R6, R7
        else              e = sext(p);                      // R2
        model = e;
        sb.push_back('{e, tag});
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_vld = 1'b0; clr = 1'b0;
    endtask

    // Monitor: compares each valid result with the head of the scoreboard.
    always @(posedge clk) begin
        #1;
        if (rst_n && sum_vld) begin
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9: unexpected valid, actual %h expected none", sum_q);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, sum_q, it.exp);
                check("R9 chain_out", chain_out, sum_q);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sum", sum_q, '0);
        check("R1 vld", {63'd0, sum_vld}, '0);
        rst_n = 1'b1;

        drive("R2 zero pos", 0, 0, 0, 0, 0, 38'd123, 64'd77, 64'd1);
        drive("R2 zero neg", 0, 0, 0, 0, 0, -38'sd5, 64'd77, 64'd1);
        drive("R3 preload", 0, 0, 1, 0, 0, 38'd100, 64'd0, 64'd1 << 7);
        drive("R3 neg ignored", 0, 1, 1, 0, 0, 38'd100, 64'd999, 64'd1 << 7);
        drive("R2 restart", 0, 0, 0, 0, 0, 38'd10, 64'd0, 64'd1);
        drive("R4 acc", 0, 0, 0, 1, 0, 38'd20, 64'd0, 64'd1);
        drive("R4 acc ldc ignored", 0, 0, 1, 1, 0, -38'sd7, 64'd0, 64'd1 << 3);
        drive("R5 neg acc", 0, 1, 0, 1, 0, 38'd5, 64'd0, 64'd1);
        drive("R6 chain", 0, 1, 0, 0, 0, 38'd300, 64'd1000, 64'd1);
        drive("R7 chain off", 0, 1, 0, 0, 1, 38'd300, 64'd1000, 64'd1);
        drive("R8 split acc", 1, 0, 0, 1, 0, 38'd9, 64'd1000, 64'd1);
        drive("R8 split chain", 1, 1, 0, 0, 0, -38'sd9, 64'd1000, 64'd1);
        go_idle();
        // R9 hold: controls move but in_vld stays low
        @(negedge clk);
        neg = 1'b1; acc = 1'b1; prod = 38'd55; split_mode = 1'b0;
        @(negedge clk);
        check("R9 hold sum", sum_q, model);
        check("R9 hold vld", {63'd0, sum_vld}, '0);
        // R10 clear wins over a valid input
        @(negedge clk);
        clr = 1'b1; in_vld = 1'b1; acc = 1'b1; neg = 1'b0; prod = 38'd44;
        @(negedge clk);
        check("R10 clr sum", sum_q, '0);
        check("R10 clr vld", {63'd0, sum_vld}, '0);
        clr = 1'b0; in_vld = 1'b0;
        model = '0;
        drive("R10 acc from zero", 0, 0, 0, 1, 0, 38'd4, 64'd0, 64'd1);
        // R11 wrap across bit 63
        drive("R11 max pos", 0, 0, 1, 0, 0, -38'sd1, 64'd0, 64'd1 << 63);
        drive("R11 wrap", 0, 0, 0, 1, 0, 38'd1, 64'd0, 64'd1);
        // Mixed back-to-back operations
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] rc;
            rc = 64'd1 << ($urandom % 64);
            drive("R4/R5/R6 random", ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                  $urandom % 2, $urandom % 2, PW'({$urandom, $urandom}),
                  {$urandom, $urandom}, rc);
        end
        go_idle();
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R9: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule